// File: doc/BRIEF.md
# I2C Controller Status Flag Register

This block holds the 16-bit status word of an I2C controller. The bus engine reports what happens on the wire through single-cycle event strobes. These cover the start and end of a master transmit, the sampled acknowledge level, a bus collision, a general-call or 10-bit address match, start and stop conditions, a device address match and a received byte. The block turns these strobes into sticky or tracking flags. The CPU reads the whole word at any time. With a status write it can clear the three error flags that only software may clear.

The block also owns the receive holding byte and the transmit holding byte. It can therefore decide locally whether a received byte overflows and whether a CPU write to the transmit byte collides with a busy transmitter. The transmitter counts as busy when the engine's `tx_busy` input is high or when the transmit-buffer-full flag is set. All strobes and CPU controls are sampled on the rising clock edge, and every flag changes one cycle after its event. Reset is synchronous and active high.

Top module: `i2c_stat_reg`

## Requirements
- R1: While `rst` is high at a clock edge, every status bit and both holding bytes become 0.
- R2: Status bits 13, 12 and 11 always read 0.
- R3: `ev_tx_start` sets bit 14 (transmit in progress). `ev_ack_end` clears bit 14 and loads bit 15 with `ack_lvl` (1 = NACK, 0 = ACK). When both strobes arrive together, bit 14 ends set.
- R4: `ev_bus_coll` sets bit 10 (bus collision). Only a status write with bit 10 of `sw_wdata` at 0 clears it. A set in the same cycle wins over the clear.
- R5: `ev_gcall` sets bit 9 (general call) and `ev_addr10` sets bit 8 (10-bit match). `ev_stop` clears both, and a set in the same cycle wins.
- R6: `ev_start` sets bit 3 and clears bit 4. `ev_stop` sets bit 4 and clears bit 3. If both arrive together, the stop wins. Bits 3 and 4 are never both 1.
- R7: `ev_addr_match` loads bit 2 (read/write) from `rw_in`. `ev_stop` clears bit 2.
- R8: A `tx_wr` while the transmitter is not busy (`tx_busy`=0 and bit 0 = 0) stores `tx_data` in `tx_hold`, sets bit 0 (transmit buffer full) and sets bit 5 (data/address). `ev_tx_load` clears bit 0.
- R9: A `tx_wr` while the transmitter is busy leaves `tx_hold`, bit 0 and bit 5 unchanged and sets bit 7 (write collision). Only a status write with bit 7 of `sw_wdata` at 0 clears bit 7.
- R10: An `ev_rx_byte` while bit 1 (receive buffer full) is 0, or while `rx_rd` is high, stores `rx_data` in `rx_hold` and sets bits 1 and 5. An `rx_rd` without an accepted byte clears bit 1.
- R11: An `ev_rx_byte` while bit 1 is 1 and `rx_rd` is 0 keeps the old `rx_hold` and sets bit 6 (overflow). Only a status write with bit 6 of `sw_wdata` at 0 clears bit 6.
- R12: `ev_addr_match` clears bit 5, and this takes priority over any set of bit 5 in the same cycle.
- R13: A status write changes no bit other than 10, 7 and 6, and a 1 written to one of those three leaves it as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_tx_start | input | 1 | Master transmit begins |
| ev_ack_end | input | 1 | End of slave acknowledge |
| ack_lvl | input | 1 | Sampled acknowledge level, 1 = NACK |
| ev_bus_coll | input | 1 | Bus collision during master operation |
| ev_gcall | input | 1 | General-call address matched |
| ev_addr10 | input | 1 | Second byte of 10-bit address matched |
| ev_stop | input | 1 | Stop condition detected |
| ev_start | input | 1 | Start condition detected |
| ev_addr_match | input | 1 | Device address matched |
| rw_in | input | 1 | Read/write bit of the matched address |
| ev_rx_byte | input | 1 | Data byte shifted in, ready to move to holding |
| rx_data | input | 8 | Byte from the receive shift register |
| rx_rd | input | 1 | CPU reads the receive holding byte |
| tx_wr | input | 1 | CPU writes the transmit holding byte |
| tx_data | input | 8 | Byte written by the CPU |
| tx_busy | input | 1 | Engine transmitter busy |
| ev_tx_load | input | 1 | Engine takes the transmit holding byte |
| sw_wr | input | 1 | CPU status write |
| sw_wdata | input | 16 | Status write data, 0 in bits 10/7/6 clears |
| rx_hold | output | 8 | Receive holding byte |
| tx_hold | output | 8 | Transmit holding byte |
| stat | output | 16 | Status word |

## Verification
The assertions check the per-cycle invariants on every cycle: the unimplemented bits stay zero, start and stop flags exclude each other, a stop clears the general-call flag, the bus collision flag does not set without cause, and an overflowing byte or a colliding write leaves its holding byte untouched. The bench scenarios cover the ordering effects that only a sequence can show. These are the priority between simultaneous events, the data/address flag tracking address versus data traffic, a read and a receive in the same cycle, and which status-write values clear which flags.

// File: rtl/i2c_stat_reg.sv
module i2c_stat_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_tx_start,
  input  logic          ev_ack_end,
  input  logic          ack_lvl,
  input  logic          ev_bus_coll,
  input  logic          ev_gcall,
  input  logic          ev_addr10,
  input  logic          ev_stop,
  input  logic          ev_start,
  input  logic          ev_addr_match,
  input  logic          rw_in,
  input  logic          ev_rx_byte,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_rd,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_busy,
  input  logic          ev_tx_load,
  input  logic          sw_wr,
  input  logic [15:0]   sw_wdata,
  output logic [DW-1:0] rx_hold,
  output logic [DW-1:0] tx_hold,
  output logic [15:0]   stat
);

  logic nack_q, txip_q, bcol_q, gc_q, a10_q, wcol_q, rov_q, da_q;
  logic stp_q, sta_q, rw_q, rbf_q, tbf_q;

  wire tx_ok  = tx_wr & ~tx_busy & ~tbf_q;
  wire tx_col = tx_wr & (tx_busy | tbf_q);
  wire rx_ok  = ev_rx_byte & (~rbf_q | rx_rd);
  wire rx_ovf = ev_rx_byte & rbf_q & ~rx_rd;
  wire clr_bc = sw_wr & ~sw_wdata[10];
  wire clr_wc = sw_wr & ~sw_wdata[7];
  wire clr_ov = sw_wr & ~sw_wdata[6];

  always_ff @(posedge clk) begin
    if (rst) begin
      {nack_q, txip_q, bcol_q, gc_q, a10_q, wcol_q, rov_q} <= '0;
      {da_q, stp_q, sta_q, rw_q, rbf_q, tbf_q} <= '0;
      rx_hold <= '0;
      tx_hold <= '0;
    end else begin
      if (ev_ack_end) nack_q <= ack_lvl;
      if (ev_tx_start) txip_q <= 1'b1;
      else if (ev_ack_end) txip_q <= 1'b0;

      if (ev_bus_coll) bcol_q <= 1'b1;
      else if (clr_bc) bcol_q <= 1'b0;

      if (ev_gcall) gc_q <= 1'b1;
      else if (ev_stop) gc_q <= 1'b0;
      if (ev_addr10) a10_q <= 1'b1;
      else if (ev_stop) a10_q <= 1'b0;

      if (tx_col) wcol_q <= 1'b1;
      else if (clr_wc) wcol_q <= 1'b0;
      if (rx_ovf) rov_q <= 1'b1;
      else if (clr_ov) rov_q <= 1'b0;

      if (ev_addr_match) da_q <= 1'b0;
      else if (tx_ok | rx_ok) da_q <= 1'b1;

      if (ev_stop) begin
        stp_q <= 1'b1;
        sta_q <= 1'b0;
      end else if (ev_start) begin
        stp_q <= 1'b0;
        sta_q <= 1'b1;
      end

      if (ev_addr_match) rw_q <= rw_in;
      else if (ev_stop) rw_q <= 1'b0;

      if (rx_ok) begin
        rbf_q   <= 1'b1;
        rx_hold <= rx_data;
      end else if (rx_rd) rbf_q <= 1'b0;

      if (tx_ok) begin
        tbf_q   <= 1'b1;
        tx_hold <= tx_data;
      end else if (ev_tx_load) tbf_q <= 1'b0;
    end
  end

  assign stat = {nack_q, txip_q, 3'b000, bcol_q, gc_q, a10_q,
                 wcol_q, rov_q, da_q, stp_q, sta_q, rw_q, rbf_q, tbf_q};

  a_r2_unimpl_zero: assert property (@(posedge clk) disable iff (rst)
    stat[13:11] == 3'b000);

  a_r6_start_stop_excl: assert property (@(posedge clk) disable iff (rst)
    !(stat[4] && stat[3]));

  a_r5_stop_clears_gc: assert property (@(posedge clk) disable iff (rst)
    (ev_stop && !ev_gcall) |=> !stat[9]);

  a_r4_no_spurious_bcol: assert property (@(posedge clk) disable iff (rst)
    (!stat[10] && !ev_bus_coll) |=> !stat[10]);

  a_r11_overflow_keeps: assert property (@(posedge clk) disable iff (rst)
    (stat[1] && ev_rx_byte && !rx_rd) |=> (stat[6] && $stable(rx_hold)));

  a_r9_collision_drops: assert property (@(posedge clk) disable iff (rst)
    (tx_wr && (tx_busy || stat[0])) |=> (stat[7] && $stable(tx_hold)));

endmodule

// File: tb/sim_i2c_stat_reg.sv
module sim_i2c_stat_reg;
  logic clk = 1'b0;
  logic rst;
  logic ev_tx_start, ev_ack_end, ack_lvl, ev_bus_coll, ev_gcall, ev_addr10;
  logic ev_stop, ev_start, ev_addr_match, rw_in, ev_rx_byte, rx_rd;
  logic tx_wr, tx_busy, ev_tx_load, sw_wr;
  logic [7:0]  rx_data, tx_data, rx_hold, tx_hold;
  logic [15:0] sw_wdata, stat;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  i2c_stat_reg u0 (.*);

  // stim: [15]tx_start [14]ack_end [13]ack_lvl [12]bus_coll [11]gcall [10]addr10
  // [9]stop [8]start [7]addr_match [6]rw [5]rx_byte [4]rx_rd [3]tx_wr [2]tx_busy
  // [1]tx_load [0]sw_wr(data 0)     expected status in the low half
  localparam int N = 23;
  localparam logic [31:0] VEC [N] = '{
    {16'h0100, 16'h0008}, // R6 start
    {16'h00C0, 16'h000C}, // R7 R12 address match, read
    {16'h0008, 16'h002D}, // R8 accepted write
    {16'h8002, 16'h402C}, // R3 R8 tx start, load
    {16'h6000, 16'h802C}, // R3 nack
    {16'h000C, 16'h80AC}, // R9 write while engine busy
    {16'h0008, 16'h80AD}, // R8
    {16'h0008, 16'h80AD}, // R9 write while buffer full
    {16'h8002, 16'hC0AC}, // R3
    {16'h4000, 16'h00AC}, // R3 ack
    {16'h1000, 16'h04AC}, // R4 collision
    {16'h0001, 16'h002C}, // R4 R9 R13 software clear
    {16'h0200, 16'h0030}, // R6 R7 stop
    {16'h0900, 16'h0228}, // R5 R6 start + general call
    {16'h0480, 16'h0308}, // R5 R12 address match + 10-bit
    {16'h0020, 16'h032A}, // R10 byte in
    {16'h0020, 16'h036A}, // R11 overflow
    {16'h0010, 16'h0368}, // R10 read
    {16'h0030, 16'h036A}, // R10 byte + read, empty
    {16'h0030, 16'h036A}, // R10 byte + read, full: accepted
    {16'h1001, 16'h072A}, // R4 R11 set wins over clear
    {16'h0300, 16'h0432}, // R5 R6 R7 stop wins
    {16'h0001, 16'h0032}  // R4 R13
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] s, input logic [15:0] wd, input int i);
    {ev_tx_start, ev_ack_end, ack_lvl, ev_bus_coll, ev_gcall, ev_addr10,
     ev_stop, ev_start, ev_addr_match, rw_in, ev_rx_byte, rx_rd,
     tx_wr, tx_busy, ev_tx_load, sw_wr} = s;
    sw_wdata = wd;
    rx_data = 8'(8'h10 + i);
    tx_data = 8'(8'hA0 + i);
  endtask

  initial begin
    rst = 1'b1;
    drive(16'h0000, 16'h0000, 0);
    repeat (3) @(negedge clk);
    chk("R1 reset status", stat, 16'h0000);
    chk("R1 reset holds", {rx_hold, tx_hold}, 16'h0000);
    rst = 1'b0;
    for (int i = 0; i < N; i++) begin
      drive(VEC[i][31:16], 16'h0000, i);
      @(negedge clk);
      chk($sformatf("R2-R13 step %0d", i), stat, VEC[i][15:0]);
      if (i == 2)  chk("R8 tx_hold stored", {8'h0, tx_hold}, 16'h00A2);
      if (i == 7)  chk("R9 tx_hold kept", {8'h0, tx_hold}, 16'h00A6);
      if (i == 16) chk("R11 rx_hold kept", {8'h0, rx_hold}, 16'h001F);
    end
    chk("R10 rx_hold read+byte", {8'h0, rx_hold}, 16'h0023);
    drive(16'h1000, 16'h0000, 0);
    @(negedge clk);
    drive(16'h0001, 16'hFFFF, 0);
    @(negedge clk);
    chk("R13 write of ones keeps", stat, 16'h0432);
    drive(16'h0001, 16'hFBFF, 0);
    @(negedge clk);
    chk("R4 write 0 to bit 10", stat, 16'h0032);
    drive(16'h0000, 16'h0000, 0);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run reset", stat, 16'h0000);
    rst = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule